// File: doc/BRIEF.md
# Board Reset and Output-Kill Arbiter

This block gathers every reset and fault source on a motion-control board. It sorts them into two reset classes and also drives a command that forces the analog motor outputs to zero. The hard-reset sources are:

- a fault flag from any monitored supply rail;
- the external reset pin;
- a host write of a fixed key value to a control register.

A hard-reset request puts the whole board back into its power-up condition. The request is stretched so that it stays active for a fixed number of cycles after the last source goes away.

An expiry pulse from the software watchdog is handled differently. It does not reboot anything. Instead it sets a sticky soft-reset flag, sends a single reset pulse to the I/O logic, and keeps the motor outputs at zero. The flag stays set until the host clears it with a register write.

The host reaches the block through a plain write strobe with an address and a data byte. The soft-reset flag is an output that the host can sample. The rail flags and the external pin cross in through two-stage synchronizers. The watchdog pulse and the host writes are already in the block's clock domain.

Top module: `reset_fault_arbiter`

## Requirements
- R1: A synchronous `rst` sets `hard_rst_o` and `zero_cmd_o` high and clears `soft_rst_o` and `io_rst_o`. After `rst` falls, `hard_rst_o` stays high for HOLD_CYC more rising edges and then drops.
- R2: A high `rail_fault_i` bit is seen by `hard_rst_o` and `zero_cmd_o` at the third rising edge after it is applied, because of two synchronizer stages and one output register.
- R3: A high `ext_rst_i` is seen by `hard_rst_o` at the third rising edge after it is applied. It gives a hard reset just as a rail fault does.
- R4: A host write to address HARD_ADDR (default 0) with data equal to KEY_VAL (default 8'hA5) sets `hard_rst_o` at the next edge. A write to HARD_ADDR with any other data value is ignored, and so is a write to any other address.
- R5: `hard_rst_o` stays high for exactly HOLD_CYC (default 16) rising edges after the last edge at which any hard source was present.
- R6: A `wd_expire_i` cycle while no hard reset is active sets `soft_rst_o` at the next edge. It does not assert `hard_rst_o`.
- R7: `io_rst_o` is a one-cycle pulse. It appears only on the edge at which the soft flag goes from clear to set, however long `wd_expire_i` stays high.
- R8: A host write to address CLR_ADDR (default 1) with data bit 0 set to 1 clears `soft_rst_o` at the next edge. The write is ignored if bit 0 is 0, and it is ignored if `wd_expire_i` is high in the same cycle.
- R9: While `hard_rst_o` is high, `soft_rst_o` is cleared at the next edge and `wd_expire_i` has no effect.
- R10: In every cycle, `zero_cmd_o` equals `hard_rst_o` OR `soft_rst_o`. So any rail fault, and any latched soft reset, forces the motor outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rail_fault_i | input | N_RAILS | One asynchronous out-of-spec flag per monitored rail |
| ext_rst_i | input | 1 | Asynchronous external reset request, active high |
| wd_expire_i | input | 1 | Watchdog expiry, synchronous, active high |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| hard_rst_o | output | 1 | Stretched hard-reset request |
| soft_rst_o | output | 1 | Latched soft-reset status |
| io_rst_o | output | 1 | One-cycle I/O reset pulse |
| zero_cmd_o | output | 1 | Force analog motor outputs to zero |

## Verification
The bench sweeps all four addresses against all 256 data values, so that exactly one pattern fires a hard reset. A decoder that ignored the address or compared only part of the key would fire on some other pattern. It measures the stretch after power-up, after a one-cycle key write and after held rail and external faults. A counter that is off by one, or reloaded on the wrong edge, shows up as a wrong measured length.

The bench also targets the soft-flag corners:
- a clear written in the same cycle as an expiry;
- a clear write with bit 0 low;
- a long expiry that must give only one I/O pulse;
- an expiry that arrives during a hard reset.

A latch with the wrong priority would drop or keep the flag when it should not. A level-driven pulse would repeat.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  // Depth of the input synchronizers for asynchronous sources.
  localparam int unsigned SYNC_STAGES = 2;

  // Decoded host write, one bit per recognised command.
  typedef struct packed {
    logic key_hit;
    logic clr_hit;
  } host_cmd_t;

endpackage

// File: rtl/rfm_sync_bank.sv
module rfm_sync_bank #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = rfm_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] shift_q;
      if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst) shift_q <= '0;
          else     shift_q <= d_i[b];
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst) shift_q <= '0;
          else     shift_q <= {shift_q[STAGES-2:0], d_i[b]};
        end
      end
      assign q_o[b] = shift_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rfm_host_decode.sv
module rfm_host_decode
  import rfm_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 2,
  parameter int unsigned            DATA_W    = 8,
  parameter logic [DATA_W-1:0]      KEY_VAL   = 8'hA5,
  parameter logic [ADDR_W-1:0]      HARD_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0]      CLR_ADDR  = 2'd1
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output host_cmd_t         cmd_o
);

  // Only the full key at the control address counts; bit 0 alone clears.
  always_comb begin
    cmd_o.key_hit = wr_i && (addr_i == HARD_ADDR) && (wdata_i == KEY_VAL);
    cmd_o.clr_hit = wr_i && (addr_i == CLR_ADDR)  && wdata_i[0];
  end

endmodule

// File: rtl/rfm_hard_hold.sv
module rfm_hard_hold #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  output logic hard_o,
  output logic hard_next_o
);

  localparam int unsigned        CNT_W   = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0]   HOLD_LD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign hard_next_o = src_i || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= HOLD_LD;
      hard_o <= 1'b1;
    end else if (src_i) begin
      cnt_q  <= HOLD_LD;
      hard_o <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      hard_o <= hard_next_o;
    end
  end

  // R5: a present source always yields an active request next cycle.
  assert_src_sets_hard_R5: assert property (@(posedge clk) disable iff (rst)
    src_i |=> hard_o);

  // R5: the request never drops right after a cycle with a source.
  assert_no_early_drop_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(hard_o) |-> !$past(src_i));

endmodule

// File: rtl/rfm_soft_latch.sv
module rfm_soft_latch (
  input  logic clk,
  input  logic rst,
  input  logic kill_i,
  input  logic expire_i,
  input  logic clr_i,
  output logic soft_o,
  output logic io_rst_o,
  output logic soft_next_o
);

  // Hard reset wins, then expiry, then host clear.
  always_comb begin
    if (kill_i)        soft_next_o = 1'b0;
    else if (expire_i) soft_next_o = 1'b1;
    else if (clr_i)    soft_next_o = 1'b0;
    else               soft_next_o = soft_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_o   <= 1'b0;
      io_rst_o <= 1'b0;
    end else begin
      soft_o   <= soft_next_o;
      io_rst_o <= !kill_i && expire_i && !soft_o;
    end
  end

  assert_expiry_latches_R6: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !kill_i) |=> soft_o);

  assert_clear_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (soft_o && expire_i && clr_i && !kill_i) |=> soft_o);

  assert_io_single_R7: assert property (@(posedge clk) disable iff (rst)
    io_rst_o |=> !io_rst_o);

  assert_hard_clears_R9: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (!soft_o && !io_rst_o));

endmodule

// File: rtl/reset_fault_arbiter.sv
module reset_fault_arbiter
  import rfm_pkg::*;
#(
  parameter int unsigned       N_RAILS   = 3,
  parameter int unsigned       HOLD_CYC  = 16,
  parameter int unsigned       ADDR_W    = 2,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] KEY_VAL   = 8'hA5,
  parameter logic [ADDR_W-1:0] HARD_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 2'd1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] rail_fault_i,
  input  logic               ext_rst_i,
  input  logic               wd_expire_i,
  input  logic               host_wr_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic               hard_rst_o,
  output logic               soft_rst_o,
  output logic               io_rst_o,
  output logic               zero_cmd_o
);

  localparam int unsigned ASYNC_W = N_RAILS + 1;

  logic [ASYNC_W-1:0] async_raw;
  logic [ASYNC_W-1:0] async_sync;
  logic               rail_any;
  logic               ext_sync;
  logic               hard_src;
  logic               hard_next;
  logic               soft_next;
  host_cmd_t          host_cmd;

  assign async_raw = {ext_rst_i, rail_fault_i};

  rfm_sync_bank #(
    .WIDTH  (ASYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (async_raw),
    .q_o (async_sync)
  );

  assign rail_any = |async_sync[N_RAILS-1:0];
  assign ext_sync = async_sync[N_RAILS];

  rfm_host_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_VAL   (KEY_VAL),
    .HARD_ADDR (HARD_ADDR),
    .CLR_ADDR  (CLR_ADDR)
  ) u_decode (
    .wr_i    (host_wr_i),
    .addr_i  (host_addr_i),
    .wdata_i (host_wdata_i),
    .cmd_o   (host_cmd)
  );

  assign hard_src = rail_any || ext_sync || host_cmd.key_hit;

  rfm_hard_hold #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk         (clk),
    .rst         (rst),
    .src_i       (hard_src),
    .hard_o      (hard_rst_o),
    .hard_next_o (hard_next)
  );

  rfm_soft_latch u_soft (
    .clk         (clk),
    .rst         (rst),
    .kill_i      (hard_rst_o),
    .expire_i    (wd_expire_i),
    .clr_i       (host_cmd.clr_hit),
    .soft_o      (soft_rst_o),
    .io_rst_o    (io_rst_o),
    .soft_next_o (soft_next)
  );

  // Registered kill command for the analog stage.
  always_ff @(posedge clk) begin
    if (rst) zero_cmd_o <= 1'b1;
    else     zero_cmd_o <= hard_next || soft_next || rail_any;
  end

  assert_zero_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    zero_cmd_o == (hard_rst_o || soft_rst_o));

  assert_rail_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rail_any |=> (zero_cmd_o && hard_rst_o));

  assert_key_hard_R4: assert property (@(posedge clk) disable iff (rst)
    host_cmd.key_hit |=> hard_rst_o);

  assert_ext_hard_R3: assert property (@(posedge clk) disable iff (rst)
    ext_sync |=> hard_rst_o);

endmodule

// File: tb/test_reset_fault_arbiter.sv
module test_reset_fault_arbiter;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned N_RAILS    = 3;
  localparam int unsigned HOLD_CYC   = 16;
  localparam logic [7:0]  KEY        = 8'hA5;
  localparam logic [1:0]  A_HARD     = 2'd0;
  localparam logic [1:0]  A_CLR      = 2'd1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [N_RAILS-1:0] rail_fault = '0;
  logic               ext_rst = 1'b0;
  logic               wd_expire = 1'b0;
  logic               host_wr = 1'b0;
  logic [1:0]         host_addr = '0;
  logic [7:0]         host_wdata = '0;
  logic               hard_rst, soft_rst, io_rst, zero_cmd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_fault_arbiter #(
    .N_RAILS  (N_RAILS),
    .HOLD_CYC (HOLD_CYC)
  ) i_reset_fault_arbiter (
    .clk          (clk),
    .rst          (rst),
    .rail_fault_i (rail_fault),
    .ext_rst_i    (ext_rst),
    .wd_expire_i  (wd_expire),
    .host_wr_i    (host_wr),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .hard_rst_o   (hard_rst),
    .soft_rst_o   (soft_rst),
    .io_rst_o     (io_rst),
    .zero_cmd_o   (zero_cmd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Counts further edges with hard_rst high; called at a negedge.
  task automatic measure_hold(output int n);
    n = 0;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!hard_rst) break;
      n++;
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hard in reset", hard_rst, 1);
    chk("R1 zero in reset", zero_cmd, 1);
    chk("R1 soft in reset", soft_rst, 0);
    chk("R1 io in reset", io_rst, 0);
    rst = 1'b0;
    measure_hold(n);
    chk("R1 power-up stretch", n, HOLD_CYC);
    chk("R1 zero after stretch", zero_cmd, 0);

    // R2 each rail alone, held three cycles
    for (int r = 0; r < N_RAILS; r++) begin
      rail_fault[r] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R2 no hard before sync", hard_rst, 0);
      @(negedge clk);
      chk("R2 hard on third edge", hard_rst, 1);
      chk("R2 zero on third edge", zero_cmd, 1);
      rail_fault[r] = 1'b0;
      measure_hold(n);
      chk("R5 rail hold length", n, 3 + HOLD_CYC - 1);
      chk("R10 zero released", zero_cmd, 0);
    end

    // R3 external pin
    ext_rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no hard before sync", hard_rst, 0);
    @(negedge clk);
    chk("R3 hard on third edge", hard_rst, 1);
    ext_rst = 1'b0;
    measure_hold(n);
    chk("R5 ext hold length", n, 3 + HOLD_CYC - 1);

    // R4 exhaustive address x data sweep
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 256; d++) begin
        host_write(a[1:0], d[7:0]);
        if (a[1:0] == A_HARD && d[7:0] == KEY) begin
          chk("R4 key write", hard_rst, 1);
          measure_hold(n);
          chk("R5 key hold length", n, HOLD_CYC);
        end else begin
          chk("R4 non-key write ignored", hard_rst, 0);
        end
      end
    end

    // R6, R7 single expiry
    wd_expire = 1'b1;
    @(negedge clk);
    wd_expire = 1'b0;
    chk("R6 soft set", soft_rst, 1);
    chk("R6 no hard", hard_rst, 0);
    chk("R7 io pulse", io_rst, 1);
    chk("R10 zero with soft", zero_cmd, 1);
    @(negedge clk);
    chk("R7 io one cycle", io_rst, 0);
    chk("R6 soft held", soft_rst, 1);

    // R8 clear with bit0 low ignored
    host_write(A_CLR, 8'hFE);
    chk("R8 bit0 low ignored", soft_rst, 1);
    // R8 clear blocked by same-cycle expiry
    wd_expire = 1'b1;
    host_write(A_CLR, 8'h01);
    wd_expire = 1'b0;
    chk("R8 clear blocked by expiry", soft_rst, 1);
    chk("R7 no pulse when already set", io_rst, 0);
    // R8 clear takes effect
    host_write(A_CLR, 8'h01);
    chk("R8 clear", soft_rst, 0);
    chk("R10 zero after clear", zero_cmd, 0);

    // R7 long expiry gives one pulse
    n = 0;
    wd_expire = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (io_rst) n++;
    end
    wd_expire = 1'b0;
    chk("R7 pulses for long expiry", n, 1);
    chk("R6 soft after long expiry", soft_rst, 1);

    // R9 hard reset clears the latch
    host_write(A_HARD, KEY);
    chk("R9 hard from key", hard_rst, 1);
    @(negedge clk);
    chk("R9 soft cleared by hard", soft_rst, 0);
    chk("R10 zero during hard", zero_cmd, 1);
    measure_hold(n);
    chk("R5 hold after key", n, HOLD_CYC - 1);
    chk("R9 soft stays clear", soft_rst, 0);

    // R9 expiry during hard reset has no effect
    host_write(A_HARD, KEY);
    wd_expire = 1'b1;
    @(negedge clk);
    wd_expire = 1'b0;
    chk("R9 expiry ignored soft", soft_rst, 0);
    chk("R9 expiry ignored io", io_rst, 0);
    measure_hold(n);
    chk("R9 soft after hard", soft_rst, 0);
    chk("R10 zero idle", zero_cmd, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule